// File: doc/BRIEF.md
# Remappable Single-Cycle Local RAM Controller

This block holds the processor's tightly coupled working RAM. It is built from two storage banks. The primary bank is 8 KB and always sits at the bottom of the processor's local address space. The secondary bank is 12 KB. After reset it belongs to a display engine, which reaches it through its own word-wide port. A one-bit select register can move the secondary bank into the processor's local space, directly above the primary bank. The processor then sees one contiguous 20 KB region, and the display engine is locked out.

The processor port takes one request per clock: valid, write, byte address, access size, a DMA tag and write data. Read data and an error flag come back from registers that update on the clock edge that samples the request, so there are no wait states. Any address that does not land on a mapped byte returns the error flag and zero read data. The same happens for a misaligned or reserved-size access and for any request tagged as DMA. A request that returns the error flag never modifies storage.

Top module: `tcram_remap_ctl`

## Requirements
- R1: A processor word access at addresses 0x0000 to 0x1FFF reaches the primary bank. It is sampled on one rising edge, and its read data and error flag (0) are valid right after that edge.
- R2: The remap bit is written from `sel_wdata` when `sel_wr` is high and resets to 0. A request sampled on the same edge as the register write uses the old mapping. Requests from the following edge onward use the new mapping.
- R3: With remap 0, a processor access to 0x2000 to 0x4FFF returns error 1 and read data 0, and a write there leaves storage unchanged.
- R4: With remap 1, processor address A in 0x2000 to 0x4FFF reaches byte A-0x2000 of the secondary bank. Display word index w is the same storage as processor address 0x2000+4w.
- R5: `cpu_size` encodes 0 as byte, 1 as half-word, 2 as word and 3 as reserved (error). Lanes are little-endian. Write data is taken from the low bits and placed at the lane given by `cpu_addr[1:0]`. Read data is returned in the low bits, zero-extended.
- R6: A half-word with `cpu_addr[0]`=1, or a word with `cpu_addr[1:0]`≠0, returns error 1 and does not write.
- R7: A request with `cpu_dma`=1 returns error 1 and read data 0, and does not write.
- R8: A processor address of 0x5000 or above returns error 1 in either mapping.
- R9: With remap 0, the display port reads and writes 32-bit words at indices 0 to 3071 with the same one-edge timing. An index of 3072 or above returns error 1 and read data 0.
- R10: With remap 1, a display access returns error 1 and read data 0, and a display write has no effect.
- R11: The contents of both banks are preserved across changes of the remap bit.
- R12: On a cycle with no processor request, the next `cpu_err` is 0 and `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_dma | input | 1 | Request is tagged as a DMA transfer |
| cpu_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data, right-justified |
| cpu_rdata | output | 32 | Processor read data, right-justified |
| cpu_err | output | 1 | Processor access error |
| vid_req | input | 1 | Display request valid |
| vid_we | input | 1 | Display write (1) or read (0) |
| vid_addr | input | 12 | Display word index into the secondary bank |
| vid_wdata | input | 32 | Display write data |
| vid_rdata | output | 32 | Display read data |
| vid_err | output | 1 | Display access error |
| sel_wr | input | 1 | Select register write strobe |
| sel_wdata | input | 1 | New remap bit value |

## Verification
A select-register write can land on the same edge as a processor or display access to the secondary bank. At that edge ownership of the bank hands over between the two ports. The bench provokes this by raising `sel_wr` in the same cycle as a request, in both directions of the remap. It expects the request to complete under the old mapping, and the next request to the same location to get the error flag under the new one. The stored words are checked from the new owner afterwards, to show that the handover lost no data.

// File: rtl/tcram_remap_ctl.sv
module tcram_remap_ctl #(
  parameter int PRI_BYTES = 8192,
  parameter int SEC_BYTES = 12288,
  parameter int AW        = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cpu_req,
  input  logic                                   cpu_we,
  input  logic                                   cpu_dma,
  input  logic [1:0]                             cpu_size,
  input  logic [AW-1:0]                          cpu_addr,
  input  logic [31:0]                            cpu_wdata,
  output logic [31:0]                            cpu_rdata,
  output logic                                   cpu_err,
  input  logic                                   vid_req,
  input  logic                                   vid_we,
  input  logic [$clog2(SEC_BYTES/4)-1:0]         vid_addr,
  input  logic [31:0]                            vid_wdata,
  output logic [31:0]                            vid_rdata,
  output logic                                   vid_err,
  input  logic                                   sel_wr,
  input  logic                                   sel_wdata
);
  localparam int PRI_WORDS = PRI_BYTES / 4;
  localparam int SEC_WORDS = SEC_BYTES / 4;
  localparam int PIW = $clog2(PRI_WORDS);
  localparam int SIW = $clog2(SEC_WORDS);
  localparam logic [AW-1:0]  SEC_LO  = AW'(PRI_BYTES);
  localparam logic [AW-1:0]  SEC_HI  = AW'(PRI_BYTES + SEC_BYTES);
  localparam logic [SIW-1:0] VID_TOP = SIW'(SEC_WORDS - 1);

  logic        remap_q;
  logic [31:0] pri_mem [PRI_WORDS];
  logic [31:0] sec_mem [SEC_WORDS];

  logic        in_pri, in_sec, misalign, cpu_ok, vid_ok;
  logic [AW-1:0]  sec_off;
  logic [PIW-1:0] pidx;
  logic [SIW-1:0] sidx;
  logic [3:0]     be;
  logic [31:0]    wlane;

  assign in_pri   = cpu_addr < SEC_LO;
  assign in_sec   = (cpu_addr >= SEC_LO) && (cpu_addr < SEC_HI);
  assign sec_off  = cpu_addr - SEC_LO;
  assign pidx     = cpu_addr[PIW+1:2];
  assign sidx     = sec_off[SIW+1:2];
  assign misalign = (cpu_size == 2'd3) ||
                    (cpu_size == 2'd1 && cpu_addr[0]) ||
                    (cpu_size == 2'd2 && cpu_addr[1:0] != 2'd0);
  assign cpu_ok   = cpu_req && !cpu_dma && !misalign &&
                    (in_pri || (in_sec && remap_q));
  assign vid_ok   = vid_req && !remap_q && (vid_addr <= VID_TOP);
  assign wlane    = cpu_wdata << {cpu_addr[1:0], 3'b000};

  always_comb begin
    case (cpu_size)
      2'd0:    be = 4'b0001 << cpu_addr[1:0];
      2'd1:    be = 4'b0011 << cpu_addr[1:0];
      default: be = 4'b1111;
    endcase
  end

  logic        rd_ok_q, sel_q, vid_rd_q;
  logic [1:0]  off_q, size_q;
  logic [31:0] pri_word_q, sec_word_q, vid_word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q  <= 1'b0;
      cpu_err  <= 1'b0;
      rd_ok_q  <= 1'b0;
      sel_q    <= 1'b0;
      off_q    <= 2'd0;
      size_q   <= 2'd0;
      vid_err  <= 1'b0;
      vid_rd_q <= 1'b0;
    end else begin
      if (sel_wr) remap_q <= sel_wdata;
      cpu_err  <= cpu_req && !cpu_ok;
      rd_ok_q  <= cpu_ok && !cpu_we;
      sel_q    <= in_sec;
      off_q    <= cpu_addr[1:0];
      size_q   <= cpu_size;
      vid_err  <= vid_req && !vid_ok;
      vid_rd_q <= vid_ok && !vid_we;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_ok && in_pri) begin
      if (cpu_we) begin
        for (int b = 0; b < 4; b++)
          if (be[b]) pri_mem[pidx][8*b +: 8] <= wlane[8*b +: 8];
      end else begin
        pri_word_q <= pri_mem[pidx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_ok && in_sec && cpu_we) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) sec_mem[sidx][8*b +: 8] <= wlane[8*b +: 8];
    end else if (vid_ok && vid_we) begin
      sec_mem[vid_addr] <= vid_wdata;
    end
    if (cpu_ok && in_sec && !cpu_we) sec_word_q <= sec_mem[sidx];
    if (vid_ok && !vid_we)           vid_word_q <= sec_mem[vid_addr];
  end

  logic [31:0] rd_word, rd_shift;
  assign rd_word  = sel_q ? sec_word_q : pri_word_q;
  assign rd_shift = rd_word >> {off_q, 3'b000};

  always_comb begin
    if (!rd_ok_q)           cpu_rdata = 32'd0;
    else if (size_q == 2'd0) cpu_rdata = {24'd0, rd_shift[7:0]};
    else if (size_q == 2'd1) cpu_rdata = {16'd0, rd_shift[15:0]};
    else                     cpu_rdata = rd_shift;
  end

  assign vid_rdata = vid_rd_q ? vid_word_q : 32'd0;
endmodule

// File: rtl/tcram_remap_chk.sv
module tcram_remap_chk #(
  parameter int PRI_BYTES = 8192,
  parameter int SEC_BYTES = 12288,
  parameter int AW        = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_dma,
  input logic [1:0]    cpu_size,
  input logic [AW-1:0] cpu_addr,
  input logic [31:0]   cpu_rdata,
  input logic          cpu_err,
  input logic          vid_req,
  input logic [31:0]   vid_rdata,
  input logic          vid_err,
  input logic          sel_wr,
  input logic          sel_wdata,
  input logic          remap_q
);
  localparam logic [AW-1:0] SEC_LO = AW'(PRI_BYTES);
  localparam logic [AW-1:0] SEC_HI = AW'(PRI_BYTES + SEC_BYTES);

  // R1
  pri_word_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_dma && cpu_size == 2'd2 && cpu_addr[1:0] == 2'd0 && cpu_addr < SEC_LO
    |=> !cpu_err);

  // R2
  remap_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> remap_q == $past(sel_wdata));

  // R3
  hole_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !remap_q && cpu_addr >= SEC_LO && cpu_addr < SEC_HI
    |=> cpu_err && cpu_rdata == 32'd0);

  // R6
  misalign_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_size == 2'd2 && cpu_addr[1:0] != 2'd0 |=> cpu_err);

  // R7
  dma_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_dma |=> cpu_err && cpu_rdata == 32'd0);

  // R8
  beyond_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_addr >= SEC_HI |=> cpu_err);

  // R10
  vid_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req && remap_q |=> vid_err && vid_rdata == 32'd0);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |=> !cpu_err && cpu_rdata == 32'd0);
endmodule

bind tcram_remap_ctl tcram_remap_chk #(
  .PRI_BYTES(PRI_BYTES), .SEC_BYTES(SEC_BYTES), .AW(AW)
) u_chk (.*);

// File: tb/tb_tcram_remap_ctl.sv
`timescale 1ns/1ps
module tb_tcram_remap_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0, cpu_dma = 0;
  logic [1:0]  cpu_size = 0;
  logic [15:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic [31:0] cpu_rdata;
  logic        cpu_err;
  logic        vid_req = 0, vid_we = 0;
  logic [11:0] vid_addr = 0;
  logic [31:0] vid_wdata = 0;
  logic [31:0] vid_rdata;
  logic        vid_err;
  logic        sel_wr = 0, sel_wdata = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcram_remap_ctl dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    cpu_req = 0; cpu_we = 0; cpu_dma = 0; vid_req = 0; vid_we = 0; sel_wr = 0;
  endtask

  task automatic cpu_op(input logic we, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] wd, input logic dma,
                        output logic [31:0] rd, output logic er);
    cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd; cpu_dma = dma;
    @(posedge clk); @(negedge clk);
    rd = cpu_rdata; er = cpu_err;
    idle_all();
  endtask

  task automatic vid_op(input logic we, input logic [11:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
    vid_req = 1; vid_we = we; vid_addr = a; vid_wdata = wd;
    @(posedge clk); @(negedge clk);
    rd = vid_rdata; er = vid_err;
    idle_all();
  endtask

  task automatic set_remap(input logic v);
    sel_wr = 1; sel_wdata = v;
    @(posedge clk); @(negedge clk);
    idle_all();
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic er;
    check("R12 reset err", {31'd0, cpu_err}, 32'd0);
    check("R12 reset rdata", cpu_rdata, 32'd0);
    cpu_op(0, 2'd2, 16'h2000, 0, 0, rd, er);
    check("R2 reset remap 0 hole err", {31'd0, er}, 32'd1);
  endtask

  task automatic t_primary();
    logic [31:0] rd; logic er;
    cpu_op(1, 2'd2, 16'h0000, 32'hA5A51234, 0, rd, er);
    check("R1 write err", {31'd0, er}, 32'd0);
    cpu_op(0, 2'd2, 16'h0000, 0, 0, rd, er);
    check("R1 readback", rd, 32'hA5A51234);
    cpu_op(1, 2'd2, 16'h1FFC, 32'h600DCAFE, 0, rd, er);
    cpu_op(0, 2'd2, 16'h1FFC, 0, 0, rd, er);
    check("R1 top word", rd, 32'h600DCAFE);
    check("R1 top err", {31'd0, er}, 32'd0);
  endtask

  task automatic t_lanes();
    logic [31:0] rd; logic er;
    cpu_op(1, 2'd2, 16'h0100, 32'h11223344, 0, rd, er);
    cpu_op(1, 2'd0, 16'h0101, 32'h000000AB, 0, rd, er);
    cpu_op(0, 2'd2, 16'h0100, 0, 0, rd, er);
    check("R5 byte lane write", rd, 32'h1122AB44);
    cpu_op(0, 2'd0, 16'h0103, 0, 0, rd, er);
    check("R5 byte read lane3", rd, 32'h00000011);
    cpu_op(0, 2'd0, 16'h0101, 0, 0, rd, er);
    check("R5 byte read lane1", rd, 32'h000000AB);
    cpu_op(0, 2'd1, 16'h0102, 0, 0, rd, er);
    check("R5 half read upper", rd, 32'h00001122);
    cpu_op(1, 2'd1, 16'h0102, 32'h0000BEEF, 0, rd, er);
    cpu_op(0, 2'd2, 16'h0100, 0, 0, rd, er);
    check("R5 half write upper", rd, 32'hBEEFAB44);
    cpu_op(0, 2'd3, 16'h0100, 0, 0, rd, er);
    check("R5 reserved size err", {31'd0, er}, 32'd1);
    check("R5 reserved size rdata", rd, 32'd0);
  endtask

  task automatic t_misalign();
    logic [31:0] rd; logic er;
    cpu_op(1, 2'd2, 16'h0104, 32'h01020304, 0, rd, er);
    cpu_op(1, 2'd2, 16'h0105, 32'hFFFFFFFF, 0, rd, er);
    check("R6 word misalign err", {31'd0, er}, 32'd1);
    cpu_op(0, 2'd2, 16'h0104, 0, 0, rd, er);
    check("R6 word misalign no write", rd, 32'h01020304);
    cpu_op(1, 2'd1, 16'h0101, 32'h0000FFFF, 0, rd, er);
    check("R6 half misalign err", {31'd0, er}, 32'd1);
    cpu_op(0, 2'd2, 16'h0100, 0, 0, rd, er);
    check("R6 half misalign no write", rd, 32'hBEEFAB44);
  endtask

  task automatic t_video();
    logic [31:0] rd; logic er;
    vid_op(1, 12'd0, 32'hCAFE0000, rd, er);
    vid_op(1, 12'd1, 32'h00001111, rd, er);
    vid_op(1, 12'd5, 32'h55555555, rd, er);
    vid_op(1, 12'd3071, 32'h0BADF00D, rd, er);
    check("R9 vid write err", {31'd0, er}, 32'd0);
    vid_op(0, 12'd5, 0, rd, er);
    check("R9 vid read w5", rd, 32'h55555555);
    vid_op(0, 12'd3071, 0, rd, er);
    check("R9 vid read last", rd, 32'h0BADF00D);
    vid_op(0, 12'd3072, 0, rd, er);
    check("R9 vid beyond err", {31'd0, er}, 32'd1);
    check("R9 vid beyond rdata", rd, 32'd0);
  endtask

  task automatic t_hole();
    logic [31:0] rd; logic er;
    cpu_op(1, 2'd2, 16'h2000, 32'h99999999, 0, rd, er);
    check("R3 hole write err", {31'd0, er}, 32'd1);
    cpu_op(0, 2'd2, 16'h4FFC, 0, 0, rd, er);
    check("R3 hole read err", {31'd0, er}, 32'd1);
    check("R3 hole read rdata", rd, 32'd0);
    vid_op(0, 12'd0, 0, rd, er);
    check("R3 hole write ignored", rd, 32'hCAFE0000);
  endtask

  task automatic t_remapped();
    logic [31:0] rd; logic er;
    set_remap(1);
    cpu_op(0, 2'd2, 16'h2000, 0, 0, rd, er);
    check("R4 remap w0", rd, 32'hCAFE0000);
    check("R4 remap err", {31'd0, er}, 32'd0);
    cpu_op(0, 2'd2, 16'h2014, 0, 0, rd, er);
    check("R4 remap w5", rd, 32'h55555555);
    cpu_op(0, 2'd1, 16'h2002, 0, 0, rd, er);
    check("R4 remap half", rd, 32'h0000CAFE);
    cpu_op(0, 2'd2, 16'h4FFC, 0, 0, rd, er);
    check("R11 remap last word kept", rd, 32'h0BADF00D);
    cpu_op(1, 2'd2, 16'h4FFC, 32'h00000077, 0, rd, er);
    vid_op(0, 12'd0, 0, rd, er);
    check("R10 vid blocked err", {31'd0, er}, 32'd1);
    check("R10 vid blocked rdata", rd, 32'd0);
    vid_op(1, 12'd1, 32'h0000DEAD, rd, er);
    check("R10 vid blocked write err", {31'd0, er}, 32'd1);
    cpu_op(0, 2'd2, 16'h2004, 0, 0, rd, er);
    check("R10 vid write no effect", rd, 32'h00001111);
    cpu_op(0, 2'd2, 16'h5000, 0, 0, rd, er);
    check("R8 0x5000 err", {31'd0, er}, 32'd1);
    cpu_op(0, 2'd2, 16'hFFFC, 0, 0, rd, er);
    check("R8 0xFFFC err", {31'd0, er}, 32'd1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] rd; logic er;
    sel_wr = 1; sel_wdata = 0;
    cpu_op(0, 2'd2, 16'h2004, 0, 0, rd, er);
    check("R2 same-edge cpu old map err", {31'd0, er}, 32'd0);
    check("R2 same-edge cpu old map data", rd, 32'h00001111);
    cpu_op(0, 2'd2, 16'h2004, 0, 0, rd, er);
    check("R2 next cpu new map err", {31'd0, er}, 32'd1);
    vid_op(0, 12'd3071, 0, rd, er);
    check("R11 cpu write seen by vid", rd, 32'h00000077);
    cpu_op(0, 2'd2, 16'h0100, 0, 0, rd, er);
    check("R11 primary kept", rd, 32'hBEEFAB44);
    sel_wr = 1; sel_wdata = 1;
    vid_op(0, 12'd1, 0, rd, er);
    check("R2 same-edge vid old map err", {31'd0, er}, 32'd0);
    check("R2 same-edge vid old map data", rd, 32'h00001111);
    vid_op(0, 12'd1, 0, rd, er);
    check("R2 next vid new map err", {31'd0, er}, 32'd1);
    set_remap(0);
  endtask

  task automatic t_dma_idle();
    logic [31:0] rd; logic er;
    cpu_op(0, 2'd2, 16'h0000, 0, 1, rd, er);
    check("R7 dma read err", {31'd0, er}, 32'd1);
    check("R7 dma read rdata", rd, 32'd0);
    cpu_op(1, 2'd2, 16'h0000, 32'hFFFFFFFF, 1, rd, er);
    check("R7 dma write err", {31'd0, er}, 32'd1);
    @(posedge clk); @(negedge clk);
    check("R12 idle err", {31'd0, cpu_err}, 32'd0);
    check("R12 idle rdata", cpu_rdata, 32'd0);
    cpu_op(0, 2'd2, 16'h0000, 0, 0, rd, er);
    check("R7 dma write no effect", rd, 32'hA5A51234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_primary();
    t_lanes();
    t_misalign();
    t_video();
    t_hole();
    t_remapped();
    t_same_cycle();
    t_dma_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule